// File: doc/BRIEF.md
# Protection Key Access Checker

This block decides whether a single memory access must be refused because of the protection key on the page it targets. A page-table walker supplies the block with the entries of one translation, one per cycle. The entries arrive in level 3, level 2, level 1 order. Each entry comes with a valid strobe, a two-bit level tag, a page-size bit, a present bit, a user bit and a reserved-violation indication. Alongside the entries the walker provides three things:

- the attributes of the access: data write, user-mode access, instruction fetch;
- the control state: key checking enabled, long mode active, write-protect enabled;
- a rights register that holds two bits for each possible key.

The block works out which entry is the leaf of the translation. It pulls the 4-bit key from bits 62:59 of that leaf entry. It looks the key up in the rights register and applies the gating conditions. One cycle after the leaf entry is accepted, it reports a registered result: a three-bit fault code and the key index it used. Reading the entries from memory and the ordinary permission checks belong to the walker. This block only adds the key verdict.

Top module: `pkey_access_checker`

## Requirements
- R1: For a present leaf, `res_key` carries bits 62:59 of that leaf entry's data.
- R2: For key k, bit 2k of `key_rights` is the access-disable bit and bit 2k+1 is the write-disable bit.
- R3: A key fault can only be raised when all of these hold:
  - key checking is enabled and long mode is active;
  - the leaf is present and no entry of the walk flagged a reserved violation;
  - the access is not an instruction fetch;
  - every entry of the walk has its user bit set, so the page is a user page.
- R4: Once the R3 gating holds, a fault is raised in two cases:
  - the key's access-disable bit is set;
  - the access is a data write, the key's write-disable bit is set, and either write-protect is enabled or the access is a user-mode access.
- R5: The leaf is chosen as follows:
  - a level-3 entry with the page-size bit set is the leaf (1 GiB page);
  - otherwise a level-2 entry with the page-size bit set is the leaf (2 MiB page);
  - otherwise the level-1 entry is the leaf;
  - the page-size bit of a level-1 entry has no effect;
  - only the leaf's key is used.
- R6: When `key_rights` is all zeros, no key fault is raised.
- R7: `res_code` bit 0 means present, bit 1 means reserved violation and bit 2 means protection-key fault. Bit 2 is never set together with bit 1, and never without bit 0.
- R8: A non-present entry at any level ends the walk. The result then has `res_code` = 0 and `res_key` = 0.
- R9: `res_valid` is high for exactly one cycle, in the cycle after the entry that ends the walk is accepted. It is low in every other cycle of a walk.
- R10: An entry whose level tag is not the expected one (3 when idle, then 2, then 1) aborts the walk, and no result is produced. A synchronous reset returns the block to idle with `res_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ent_valid | input | 1 | Entry strobe |
| ent_level | input | 2 | Level tag of the entry (3, 2 or 1) |
| ent_data | input | 64 | Raw entry; key in bits 62:59 |
| ent_ps | input | 1 | Page-size bit of the entry |
| ent_present | input | 1 | Entry is present |
| ent_user | input | 1 | Entry permits user access |
| ent_rsvd | input | 1 | Entry has a reserved-bit violation |
| acc_write | input | 1 | Access is a data write |
| acc_user | input | 1 | Access is made in user mode |
| acc_fetch | input | 1 | Access is an instruction fetch |
| ctl_key_en | input | 1 | Key checking enabled |
| ctl_long_mode | input | 1 | Long mode active |
| ctl_wp | input | 1 | Write-protect enabled |
| key_rights | input | 32 | Two rights bits per key |
| res_valid | output | 1 | Result strobe |
| res_code | output | 3 | {key fault, reserved, present} |
| res_key | output | 4 | Key index used |

## Verification
The bench aims at the leaf choice, because a design that took the key from the level-3 entry of a 4 KiB walk would report a foreign key and a foreign verdict. It runs kernel-mode writes with write-protect cleared, where a design that ignored the write-protect term would fault wrongly. It sets a user bit to zero at a non-leaf level, where a design that looked only at the leaf would fault on a supervisor page. It also runs fetches, reserved violations and non-present entries at level 2, which must mask the fault entirely. Level tags out of order and a reset in mid-walk must produce no result, since a design that kept the stale walk state would report a result for a walk that never started.

// File: rtl/pkc_pkg.sv
package pkc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WANT2 = 2'd1,
      ST_WANT1 = 2'd2
   } walk_st_t;

   localparam logic [1:0] LVL_ONE   = 2'd1;
   localparam logic [1:0] LVL_TWO   = 2'd2;
   localparam logic [1:0] LVL_THREE = 2'd3;

   localparam int CODE_PRES = 0;
   localparam int CODE_RSVD = 1;
   localparam int CODE_PKEY = 2;
   localparam int CODE_W    = 3;
endpackage

// File: rtl/pkc_walk_seq.sv
module pkc_walk_seq
   import pkc_pkg::*;
#(
   parameter bit GIB_LEAF_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       ent_valid,
   input  logic [1:0] ent_level,
   input  logic       ent_ps,
   input  logic       ent_present,
   input  logic       ent_user,
   input  logic       ent_rsvd,
   output logic       walk_end,
   output logic       end_present,
   output logic       end_user,
   output logic       end_rsvd
);
   walk_st_t   st_q, st_d;
   logic       user_q, rsvd_q;
   logic [1:0] want_lvl;
   logic       seq_ok;
   logic       l3_leaf;
   logic       is_leaf;

   always_comb begin
      unique case (st_q)
         ST_WANT2: want_lvl = LVL_TWO;
         ST_WANT1: want_lvl = LVL_ONE;
         default:  want_lvl = LVL_THREE;
      endcase
   end

   generate
      if (GIB_LEAF_EN) begin : g_gib
         assign l3_leaf = ent_ps;
      end else begin : g_no_gib
         assign l3_leaf = 1'b0;
      end
   endgenerate

   assign seq_ok  = ent_valid && (ent_level == want_lvl);
   assign is_leaf = (ent_level == LVL_ONE) ||
                    ((ent_level == LVL_TWO) && ent_ps) ||
                    ((ent_level == LVL_THREE) && l3_leaf);

   assign walk_end    = seq_ok && (!ent_present || is_leaf);
   assign end_present = ent_present;
   assign end_user    = ((st_q == ST_IDLE) ? 1'b1 : user_q) & ent_user;
   assign end_rsvd    = ((st_q == ST_IDLE) ? 1'b0 : rsvd_q) | ent_rsvd;

   always_comb begin
      st_d = st_q;
      if (ent_valid) begin
         if (!seq_ok || walk_end)
            st_d = ST_IDLE;
         else if (ent_level == LVL_THREE)
            st_d = ST_WANT2;
         else
            st_d = ST_WANT1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         user_q <= 1'b0;
         rsvd_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (seq_ok) begin
            user_q <= end_user;
            rsvd_q <= end_rsvd;
         end
      end
   end
endmodule

// File: rtl/pkc_rights_lookup.sv
module pkc_rights_lookup #(
   parameter int KEY_W = 4,
   localparam int NKEYS    = 1 << KEY_W,
   localparam int RIGHTS_W = 2 * NKEYS
) (
   input  logic [RIGHTS_W-1:0] rights,
   input  logic [KEY_W-1:0]    key,
   output logic                key_ad,
   output logic                key_wd
);
   logic [NKEYS-1:0] ad_vec, wd_vec;

   for (genvar k = 0; k < NKEYS; k++) begin : g_split
      assign ad_vec[k] = rights[2*k];
      assign wd_vec[k] = rights[2*k+1];
   end

   assign key_ad = ad_vec[key];
   assign key_wd = wd_vec[key];
endmodule

// File: rtl/pkc_fault_eval.sv
module pkc_fault_eval (
   input  logic gate_ok,
   input  logic key_ad,
   input  logic key_wd,
   input  logic acc_write,
   input  logic acc_user,
   input  logic ctl_wp,
   output logic pk_fault
);
   logic wr_block;

   assign wr_block = key_wd && acc_write && (ctl_wp || acc_user);
   assign pk_fault = gate_ok && (key_ad || wr_block);
endmodule

// File: rtl/pkey_access_checker.sv
module pkey_access_checker
   import pkc_pkg::*;
#(
   parameter int ENT_W       = 64,
   parameter int KEY_W       = 4,
   parameter int KEY_LSB     = 59,
   parameter bit GIB_LEAF_EN = 1'b1,
   localparam int RIGHTS_W   = 2 * (1 << KEY_W)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ent_valid,
   input  logic [1:0]          ent_level,
   input  logic [ENT_W-1:0]    ent_data,
   input  logic                ent_ps,
   input  logic                ent_present,
   input  logic                ent_user,
   input  logic                ent_rsvd,
   input  logic                acc_write,
   input  logic                acc_user,
   input  logic                acc_fetch,
   input  logic                ctl_key_en,
   input  logic                ctl_long_mode,
   input  logic                ctl_wp,
   input  logic [RIGHTS_W-1:0] key_rights,
   output logic                res_valid,
   output logic [CODE_W-1:0]   res_code,
   output logic [KEY_W-1:0]    res_key
);
   generate
      if (KEY_LSB + KEY_W > ENT_W) begin : g_bad_field
         $error("key field lies outside the entry");
      end
      if (KEY_W < 1 || KEY_W > 8) begin : g_bad_keyw
         $error("KEY_W must lie between 1 and 8");
      end
   endgenerate

   logic             walk_end, end_present, end_user, end_rsvd;
   logic [KEY_W-1:0] leaf_key;
   logic             key_ad, key_wd;
   logic             gate_ok, pk_fault;

   pkc_walk_seq #(.GIB_LEAF_EN(GIB_LEAF_EN)) u_seq (
      .clk         (clk),
      .rst         (rst),
      .ent_valid   (ent_valid),
      .ent_level   (ent_level),
      .ent_ps      (ent_ps),
      .ent_present (ent_present),
      .ent_user    (ent_user),
      .ent_rsvd    (ent_rsvd),
      .walk_end    (walk_end),
      .end_present (end_present),
      .end_user    (end_user),
      .end_rsvd    (end_rsvd)
   );

   assign leaf_key = ent_data[KEY_LSB +: KEY_W];

   pkc_rights_lookup #(.KEY_W(KEY_W)) u_lookup (
      .rights (key_rights),
      .key    (leaf_key),
      .key_ad (key_ad),
      .key_wd (key_wd)
   );

   assign gate_ok = ctl_key_en && ctl_long_mode && end_present && !end_rsvd &&
                    !acc_fetch && end_user;

   pkc_fault_eval u_eval (
      .gate_ok   (gate_ok),
      .key_ad    (key_ad),
      .key_wd    (key_wd),
      .acc_write (acc_write),
      .acc_user  (acc_user),
      .ctl_wp    (ctl_wp),
      .pk_fault  (pk_fault)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid <= 1'b0;
         res_code  <= '0;
         res_key   <= '0;
      end else begin
         res_valid <= walk_end;
         if (walk_end) begin
            res_code            <= '0;
            res_key             <= '0;
            if (end_present) begin
               res_code[CODE_PRES] <= 1'b1;
               res_code[CODE_RSVD] <= end_rsvd;
               res_code[CODE_PKEY] <= pk_fault;
               res_key             <= leaf_key;
            end
         end
      end
   end
endmodule

// File: rtl/pkc_checker.sv
module pkc_checker
   import pkc_pkg::*;
#(
   parameter int KEY_W    = 4,
   parameter int RIGHTS_W = 32
) (
   input logic                clk,
   input logic                rst,
   input logic                ent_valid,
   input logic                acc_fetch,
   input logic                ctl_key_en,
   input logic                ctl_long_mode,
   input logic [RIGHTS_W-1:0] key_rights,
   input logic                res_valid,
   input logic [CODE_W-1:0]   res_code,
   input logic [KEY_W-1:0]    res_key
);
   assert_pkey_needs_present_R7: assert property (@(posedge clk) disable iff (rst)
      (res_valid && res_code[CODE_PKEY]) |-> (res_code[CODE_PRES] && !res_code[CODE_RSVD]));

   assert_absent_clears_R8: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !res_code[CODE_PRES]) |-> (res_code == '0 && res_key == '0));

   assert_result_follows_entry_R9: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> $past(ent_valid));

   assert_fault_gated_R3: assert property (@(posedge clk) disable iff (rst)
      (res_valid && res_code[CODE_PKEY]) |-> $past(ctl_key_en && ctl_long_mode && !acc_fetch));

   assert_zero_rights_R6: assert property (@(posedge clk) disable iff (rst)
      (res_valid && res_code[CODE_PKEY]) |-> ($past(key_rights) != '0));

   assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !res_valid);
endmodule

bind pkey_access_checker pkc_checker #(.KEY_W(KEY_W), .RIGHTS_W(RIGHTS_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .ent_valid     (ent_valid),
   .acc_fetch     (acc_fetch),
   .ctl_key_en    (ctl_key_en),
   .ctl_long_mode (ctl_long_mode),
   .key_rights    (key_rights),
   .res_valid     (res_valid),
   .res_code      (res_code),
   .res_key       (res_key)
);

// File: tb/pkey_access_checker_tb.sv
module pkey_access_checker_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ent_valid = 1'b0;
   logic [1:0]  ent_level = 2'd0;
   logic [63:0] ent_data = '0;
   logic        ent_ps = 1'b0, ent_present = 1'b0, ent_user = 1'b0, ent_rsvd = 1'b0;
   logic        acc_write = 1'b0, acc_user = 1'b0, acc_fetch = 1'b0;
   logic        ctl_key_en = 1'b0, ctl_long_mode = 1'b0, ctl_wp = 1'b0;
   logic [31:0] key_rights = '0;
   logic        res_valid;
   logic [2:0]  res_code;
   logic [3:0]  res_key;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // walk description
   int          w_n;
   logic [1:0]  w_lvl  [3];
   logic [63:0] w_data [3];
   logic        w_ps   [3];
   logic        w_pres [3];
   logic        w_user [3];
   logic        w_rsvd [3];

   always #10 clk = ~clk;

   pkey_access_checker u_dut (
      .clk(clk), .rst(rst), .ent_valid(ent_valid), .ent_level(ent_level),
      .ent_data(ent_data), .ent_ps(ent_ps), .ent_present(ent_present),
      .ent_user(ent_user), .ent_rsvd(ent_rsvd), .acc_write(acc_write),
      .acc_user(acc_user), .acc_fetch(acc_fetch), .ctl_key_en(ctl_key_en),
      .ctl_long_mode(ctl_long_mode), .ctl_wp(ctl_wp), .key_rights(key_rights),
      .res_valid(res_valid), .res_code(res_code), .res_key(res_key)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] key_of(logic [63:0] d);
      return d[62:59];
   endfunction

   // expected {code, key} from the walk description and current attributes
   function automatic logic [6:0] model();
      logic u, r, p, gate, ad, wd, f;
      logic [3:0] k;
      u = 1'b1; r = 1'b0;
      for (int i = 0; i < w_n; i++) begin
         u = u & w_user[i];
         r = r | w_rsvd[i];
      end
      p = w_pres[w_n-1];
      if (!p) return 7'd0;
      k    = key_of(w_data[w_n-1]);
      ad   = key_rights[2*k];
      wd   = key_rights[2*k+1];
      gate = ctl_key_en && ctl_long_mode && !r && !acc_fetch && u;
      f    = gate && (ad || (wd && acc_write && (ctl_wp || acc_user)));
      return {f, r, 1'b1, k};
   endfunction

   task automatic idle();
      @(negedge clk);
      ent_valid = 1'b0;
   endtask

   task automatic send(int i);
      @(negedge clk);
      chk("R9 quiet during walk", {31'd0, res_valid}, 32'd0);
      ent_valid   = 1'b1;
      ent_level   = w_lvl[i];
      ent_data    = w_data[i];
      ent_ps      = w_ps[i];
      ent_present = w_pres[i];
      ent_user    = w_user[i];
      ent_rsvd    = w_rsvd[i];
   endtask

   task automatic run_walk(string req);
      logic [6:0] e;
      for (int i = 0; i < w_n; i++) send(i);
      e = model();
      @(negedge clk);
      ent_valid = 1'b0;
      chk({req, " R9 valid"}, {31'd0, res_valid}, 32'd1);
      chk({req, " R7 code"}, {29'd0, res_code}, {29'd0, e[6:4]});
      chk({req, " R1 key"}, {28'd0, res_key}, {28'd0, e[3:0]});
      @(negedge clk);
      chk({req, " R9 single pulse"}, {31'd0, res_valid}, 32'd0);
   endtask

   // leaf level 3..1; np_lvl = level holding a non-present entry (0 none)
   task automatic build(int leaf, int np_lvl, logic [3:0] key);
      w_n = 0;
      for (int l = 3; l >= leaf; l--) begin
         w_lvl[w_n]  = 2'(l);
         w_data[w_n] = {$urandom, $urandom};
         w_data[w_n][62:59] = (l == leaf) ? key : 4'(~key);
         w_ps[w_n]   = (l == leaf) ? 1'b1 : 1'b0;
         if (l == 1) w_ps[w_n] = 1'($urandom);
         w_pres[w_n] = 1'b1;
         w_user[w_n] = 1'b1;
         w_rsvd[w_n] = 1'b0;
         if (l == np_lvl) begin
            w_pres[w_n] = 1'b0;
            w_n++;
            break;
         end
         w_n++;
      end
   endtask

   task automatic attrs(bit wr, bit us, bit fe, bit ke, bit lm, bit wp);
      acc_write = wr; acc_user = us; acc_fetch = fe;
      ctl_key_en = ke; ctl_long_mode = lm; ctl_wp = wp;
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R10 reset valid", {31'd0, res_valid}, 32'd0);
      chk("R10 reset code", {29'd0, res_code}, 32'd0);

      // R1/R2: AD of key 15 is bit 30
      attrs(0, 0, 0, 1, 1, 0);
      key_rights = 32'h4000_0000;
      build(1, 0, 4'hF); run_walk("R1 R2 ad key15");
      // R2: WD of key 0 is bit 1, write in user mode, wp clear
      key_rights = 32'h0000_0002;
      attrs(1, 1, 0, 1, 1, 0);
      build(2, 0, 4'h0); run_walk("R2 R4 wd user write");
      // R4: kernel write, wp clear -> no fault
      attrs(1, 0, 0, 1, 1, 0);
      build(2, 0, 4'h0); run_walk("R4 kernel no wp");
      // R4: kernel write, wp set -> fault
      attrs(1, 0, 0, 1, 1, 1);
      build(3, 0, 4'h0); run_walk("R4 kernel wp");
      // R4: read with WD only -> no fault
      attrs(0, 1, 0, 1, 1, 1);
      build(3, 0, 4'h0); run_walk("R4 read wd");
      // R5: leaf key differs from upper keys; rights fault only the leaf key
      key_rights = 32'h0000_0100;   // AD of key 4
      attrs(0, 1, 0, 1, 1, 0);
      build(1, 0, 4'h4); run_walk("R5 leaf L1");
      build(2, 0, 4'h4); run_walk("R5 leaf L2");
      build(3, 0, 4'h4); run_walk("R5 leaf L3");
      // R3 gating
      key_rights = 32'hFFFF_FFFF;
      attrs(1, 1, 1, 1, 1, 1); build(1, 0, 4'h7); run_walk("R3 fetch");
      attrs(1, 1, 0, 0, 1, 1); build(1, 0, 4'h7); run_walk("R3 key off");
      attrs(1, 1, 0, 1, 0, 1); build(1, 0, 4'h7); run_walk("R3 no long");
      attrs(1, 1, 0, 1, 1, 1); build(1, 0, 4'h7); w_user[1] = 1'b0;
      run_walk("R3 supervisor upper");
      build(1, 0, 4'h7); w_rsvd[0] = 1'b1; run_walk("R3 R7 reserved");
      // R6
      key_rights = 32'h0;
      build(1, 0, 4'h7); run_walk("R6 zero rights");
      // R8
      key_rights = 32'hFFFF_FFFF;
      build(1, 2, 4'h7); run_walk("R8 absent L2");
      build(1, 3, 4'h7); run_walk("R8 absent L3");

      // R10: level 2 while idle
      build(2, 0, 4'h3);
      @(negedge clk);
      ent_valid = 1'b1; ent_level = 2'd2; ent_ps = 1'b1; ent_present = 1'b1;
      idle();
      chk("R10 bad start", {31'd0, res_valid}, 32'd0);
      // R10: two level-3 entries in a row
      @(negedge clk);
      ent_valid = 1'b1; ent_level = 2'd3; ent_ps = 1'b0;
      @(negedge clk);
      ent_level = 2'd3; ent_ps = 1'b0;
      @(negedge clk);
      ent_level = 2'd1;
      idle();
      chk("R10 repeated L3 no result", {31'd0, res_valid}, 32'd0);
      // R10: reset in mid walk
      @(negedge clk);
      ent_valid = 1'b1; ent_level = 2'd3; ent_ps = 1'b0;
      @(negedge clk);
      ent_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0; ent_valid = 1'b1; ent_level = 2'd2; ent_ps = 1'b1;
      idle();
      chk("R10 reset mid walk", {31'd0, res_valid}, 32'd0);
      idle();
      build(2, 0, 4'h9); run_walk("R10 recovery");

      // random walks
      for (int t = 0; t < 400; t++) begin
         int leaf, np;
         leaf = 1 + int'($urandom_range(2));
         np   = ($urandom_range(7) == 0) ? leaf + int'($urandom_range(3 - leaf)) : 0;
         build(leaf, np, 4'($urandom));
         for (int i = 0; i < w_n; i++) begin
            w_user[i] = ($urandom_range(5) != 0);
            w_rsvd[i] = ($urandom_range(9) == 0);
         end
         key_rights = ($urandom_range(7) == 0) ? 32'h0 : ($urandom & $urandom);
         attrs(1'($urandom), 1'($urandom), ($urandom_range(4) == 0),
               ($urandom_range(5) != 0), ($urandom_range(5) != 0), 1'($urandom));
         run_walk("R4 random");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule